// File: doc/BRIEF.md
# Weigh-Scale ADC Reader

This block is the host-side controller for a bridge-sensor converter that has a two-wire serial link. The converter signals a finished conversion by pulling its data line low. It then shifts out its result one bit per clock pulse, and it counts the pulses it receives to choose the input channel and gain of the next conversion. The reader waits for the ready indication and generates the serial clock from the system clock. The high and low phases it produces have fixed lengths. It collects the 24 result bits, most significant first, and presents the two's-complement word sign-extended to 32 bits with a single-cycle strobe.

One to three trailing pulses follow the data bits, and a two-bit request code selects how many. A long clock-high phase doubles as the converter's power-down command. For this reason every ordinary high phase is held to a parameter that is checked at elaboration against the power-down hold. Holding the clock high on request powers the converter down. Releasing the clock wakes the converter, which returns to channel A at gain 128. An optional timeout ends a read whose ready indication never arrives.

All timings are parameters given in system-clock cycles. The defaults suit a 50 MHz clock: 0.2 µs high and low phases, 0.1 µs of setup after ready, and 62 µs of power-down hold.

Top module: `loadcell_adc_reader`

## Requirements
- R1: With no read in progress, `sclk_o` is low. A read request taken in idle raises `busy_o` from the next cycle. No clock pulse is issued while the synchronised data line is still high.
- R2: The first rising edge of `sclk_o` comes at least `SETUP_CYC` cycles after the data line falls.
- R3: Each read pulse is high for exactly `HIGH_CYC` cycles. Consecutive pulses are separated by exactly `LOW_CYC` low cycles. Elaboration fails when `HIGH_CYC` is not below `PD_HOLD_CYC`.
- R4: Data bits are taken MSB first, one per pulse, from the synchronised line at the last cycle of the low phase that follows each of the first 24 pulses.
- R5: The request code, sampled when the read is accepted, sets the pulse total: 00 gives 25 (channel A, gain 128), 01 gives 26 (channel B, gain 32), 10 gives 27 (channel A, gain 64), and 11 is treated as 00.
- R6: After the low phase of the final pulse, `result_o` holds the 24-bit word sign-extended to 32 bits. `result_vld_o` is high for exactly one cycle.
- R7: The saturation codes pass through unchanged: 0x800000 gives 0xFF800000 and 0x7FFFFF gives 0x007FFFFF.
- R8: A power-down request in idle takes priority over a read request and drives `sclk_o` high. `powered_dn_o` rises after `sclk_o` has been high for `PD_HOLD_CYC` cycles. Dropping the request lowers `sclk_o` and `powered_dn_o` in the next cycle.
- R9: A power-down request or read request that arrives during a read is ignored until the read completes. A held power-down request takes effect in the first idle cycle.
- R10: When `TIMEOUT_CYC` is non-zero and the line stays high for `TIMEOUT_CYC` waiting cycles, `timeout_o` pulses for one cycle, `TIMEOUT_CYC`+1 cycles after the request is driven. The reader then returns to idle with no pulse issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data / ready line from the converter |
| rd_req_i | input | 1 | Start a read (sampled in idle) |
| cfg_i | input | 2 | Channel/gain code for the next conversion |
| pd_req_i | input | 1 | Power-down request (level) |
| sclk_o | output | 1 | Serial clock / power-down line to the converter |
| result_o | output | 32 | Sign-extended conversion result |
| result_vld_o | output | 1 | One-cycle strobe: result_o is new |
| busy_o | output | 1 | A read is in progress |
| powered_dn_o | output | 1 | Power-down hold time has elapsed |
| timeout_o | output | 1 | One-cycle strobe: ready never arrived |

## Verification
The hardest situation to reach is a power-down or second read request that arrives in the middle of a read. It must be held off without disturbing the pulse count or the assembled word. The bench raises both requests once the third pulse has been seen. It then checks that the read still ends with the correct word and pulse total, and that the clock goes high for power-down only in the first idle cycle. A behavioural converter model reacts to every rising clock edge. Per-clock monitoring of high and low run lengths checks the timing of every pulse across all codes.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_DONE,
    ST_TOUT,
    ST_PD
  } lcr_state_e;

  localparam int unsigned LCR_DATA_BITS = 24;
  localparam int unsigned LCR_MAX_TRAIL = 3;
endpackage

// File: rtl/lcr_sync.sv
module lcr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lcr_trail_decode.sv
module lcr_trail_decode #(
  parameter int unsigned DATA_BITS = 24,
  parameter int unsigned PCNT_W    = 5
) (
  input  logic [1:0]        code_i,
  output logic [PCNT_W-1:0] total_o
);
  logic [PCNT_W-1:0] extra;

  always_comb begin
    unique case (code_i)
      2'b01:   extra = PCNT_W'(2);
      2'b10:   extra = PCNT_W'(3);
      default: extra = PCNT_W'(1);
    endcase
    total_o = PCNT_W'(DATA_BITS) + extra;
  end
endmodule

// File: rtl/lcr_shift_in.sv
module lcr_shift_in #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q, word_d;
  logic         word_en;

  always_comb begin
    word_en = clr_i | en_i;
    word_d  = clr_i ? '0 : {word_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_o = word_q;

  assert_no_clr_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_i && en_i));
endmodule

// File: rtl/loadcell_adc_reader.sv
module loadcell_adc_reader
  import lcr_pkg::*;
#(
  parameter int unsigned HIGH_CYC    = 10,
  parameter int unsigned LOW_CYC     = 10,
  parameter int unsigned SETUP_CYC   = 5,
  parameter int unsigned PD_HOLD_CYC = 3100,
  parameter int unsigned TIMEOUT_CYC = 2000,
  parameter int unsigned DATA_BITS   = LCR_DATA_BITS,
  parameter int unsigned OUT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata_i,
  input  logic             rd_req_i,
  input  logic [1:0]       cfg_i,
  input  logic             pd_req_i,
  output logic             sclk_o,
  output logic [OUT_W-1:0] result_o,
  output logic             result_vld_o,
  output logic             busy_o,
  output logic             powered_dn_o,
  output logic             timeout_o
);
  localparam int unsigned MAX_A   = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int unsigned MAX_B   = (MAX_A > SETUP_CYC) ? MAX_A : SETUP_CYC;
  localparam int unsigned MAX_C   = (MAX_B > PD_HOLD_CYC) ? MAX_B : PD_HOLD_CYC;
  localparam int unsigned MAX_CNT = (MAX_C > TIMEOUT_CYC) ? MAX_C : TIMEOUT_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1) + 1;
  localparam int unsigned PCNT_W  = $clog2(DATA_BITS + LCR_MAX_TRAIL + 1);

  localparam logic [CNT_W-1:0]  ONE        = CNT_W'(1);
  localparam logic [CNT_W-1:0]  HIGH_LAST  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0]  LOW_LAST   = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0]  SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0]  PD_LAST    = CNT_W'(PD_HOLD_CYC - 1);
  localparam logic [CNT_W-1:0]  TOUT_LAST  = (TIMEOUT_CYC == 0) ? '0 : CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [PCNT_W-1:0] LAST_DATA  = PCNT_W'(DATA_BITS);
  localparam logic [PCNT_W-1:0] MAX_TOTAL  = PCNT_W'(DATA_BITS + LCR_MAX_TRAIL);

  // Elaboration checks on the timing parameters (R3)
  if (HIGH_CYC >= PD_HOLD_CYC) begin : g_bad_high
    $error("HIGH_CYC must stay below PD_HOLD_CYC");
  end
  if (HIGH_CYC < 1 || LOW_CYC < 1 || SETUP_CYC < 1 || PD_HOLD_CYC < 2) begin : g_bad_len
    $error("phase lengths must be at least one cycle");
  end
  if (OUT_W <= DATA_BITS) begin : g_bad_out
    $error("OUT_W must exceed DATA_BITS");
  end

  lcr_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [PCNT_W-1:0] total_q, total_new;
  logic              total_en;
  logic              pd_flag_q, pd_flag_d;
  logic              sclk_q, sclk_d;
  logic [OUT_W-1:0]  result_q, result_d;
  logic              result_en;
  logic              shift_en, shift_clr;
  logic              sdata_s;
  logic [DATA_BITS-1:0] word;

  lcr_sync #(.STAGES(2), .RST_VAL(1'b1)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sdata_i),
    .q_o   (sdata_s)
  );

  lcr_trail_decode #(.DATA_BITS(DATA_BITS), .PCNT_W(PCNT_W)) i_trail (
    .code_i  (cfg_i),
    .total_o (total_new)
  );

  lcr_shift_in #(.W(DATA_BITS)) i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (shift_clr),
    .en_i   (shift_en),
    .bit_i  (sdata_s),
    .word_o (word)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pcnt_d    = pcnt_q;
    pd_flag_d = pd_flag_q;
    total_en  = 1'b0;
    shift_en  = 1'b0;
    shift_clr = 1'b0;
    result_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pd_req_i) begin
          state_d = ST_PD;
          cnt_d   = '0;
        end else if (rd_req_i) begin
          state_d   = ST_WAIT;
          cnt_d     = '0;
          pcnt_d    = '0;
          shift_clr = 1'b1;
          total_en  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!sdata_s) begin
          state_d = ST_SETUP;
          cnt_d   = SETUP_LAST;
        end else if (TIMEOUT_CYC != 0) begin
          if (cnt_q == TOUT_LAST) state_d = ST_TOUT;
          else                    cnt_d   = cnt_q + ONE;
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_HIGH;
          cnt_d   = HIGH_LAST;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_HIGH: begin
        if (cnt_q == '0) begin
          state_d = ST_LOW;
          cnt_d   = LOW_LAST;
          pcnt_d  = pcnt_q + PCNT_W'(1);
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_LOW: begin
        if (cnt_q == '0) begin
          shift_en = (pcnt_q <= LAST_DATA);
          if (pcnt_q == total_q) begin
            state_d   = ST_DONE;
            result_en = 1'b1;
          end else begin
            state_d = ST_HIGH;
            cnt_d   = HIGH_LAST;
          end
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      ST_TOUT: state_d = ST_IDLE;
      ST_PD: begin
        if (!pd_req_i) begin
          state_d   = ST_IDLE;
          pd_flag_d = 1'b0;
        end else if (cnt_q == PD_LAST) begin
          pd_flag_d = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    sclk_d   = (state_d == ST_HIGH) || (state_d == ST_PD);
    result_d = {{(OUT_W-DATA_BITS){word[DATA_BITS-1]}}, word};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      pcnt_q    <= '0;
      pd_flag_q <= 1'b0;
      sclk_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      pcnt_q    <= pcnt_d;
      pd_flag_q <= pd_flag_d;
      sclk_q    <= sclk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        total_q <= '0;
    else if (total_en) total_q <= total_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (result_en) result_q <= result_d;
  end

  assign sclk_o       = sclk_q;
  assign result_o     = result_q;
  assign result_vld_o = (state_q == ST_DONE);
  assign busy_o       = (state_q == ST_WAIT) || (state_q == ST_SETUP) || (state_q == ST_HIGH)
                     || (state_q == ST_LOW) || (state_q == ST_DONE);
  assign powered_dn_o = pd_flag_q;
  assign timeout_o    = (state_q == ST_TOUT);

  // Checker state: length of the current read-pulse high run
  logic [CNT_W-1:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_run_q <= '0;
    else if (sclk_q && state_q != ST_PD) hi_run_q <= hi_run_q + ONE;
    else                                 hi_run_q <= '0;
  end

  assert_high_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && state_q != ST_PD) |-> (hi_run_q < CNT_W'(HIGH_CYC)));
  assert_wait_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !sclk_o);
  assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o);
  assert_pulse_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |-> (pcnt_q == total_q && total_q > LAST_DATA && total_q <= MAX_TOTAL));
  assert_pd_clock_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    powered_dn_o |-> sclk_o);
  assert_no_pd_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && pd_req_i) |=> !powered_dn_o);
  assert_timeout_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> (!busy_o && !sclk_o));
endmodule

// File: tb/test_loadcell_adc_reader.sv
`timescale 1ns/1ps
module test_loadcell_adc_reader;
  localparam int HIGH_CYC    = 10;
  localparam int LOW_CYC     = 10;
  localparam int SETUP_CYC   = 5;
  localparam int PD_HOLD_CYC = 3100;
  localparam int TIMEOUT_CYC = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdata = 1'b1;
  logic        rd_req = 1'b0;
  logic [1:0]  cfg = 2'b00;
  logic        pd_req = 1'b0;
  logic        sclk, vld, busy, pdn, tout;
  logic [31:0] result;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  loadcell_adc_reader #(
    .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC), .SETUP_CYC(SETUP_CYC),
    .PD_HOLD_CYC(PD_HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_loadcell_adc_reader (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .rd_req_i(rd_req), .cfg_i(cfg),
    .pd_req_i(pd_req), .sclk_o(sclk), .result_o(result), .result_vld_o(vld),
    .busy_o(busy), .powered_dn_o(pdn), .timeout_o(tout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural converter: one bit per rising edge, line high after the data bits
  logic [23:0] dev_word = '0;
  int          dev_cnt  = 99;
  always @(posedge sclk) begin
    #3;
    if (dev_cnt < 24) sdata = dev_word[23 - dev_cnt];
    else              sdata = 1'b1;
    dev_cnt++;
  end

  // Per-clock reference of pulse timing
  int   pulses = 0, hi_run = 0, lo_run = 0, since_fall = 0;
  bit   pd_mode = 0;
  logic prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sdata == 1'b0 && pulses == 0) since_fall++;
      if (sclk && !prev_sclk) begin
        pulses++;
        if (!pd_mode) begin
          if (pulses == 1) chk("R2 setup before first edge", 32'(since_fall >= SETUP_CYC), 32'd1);
          else             chk("R3 low time", 32'(lo_run), 32'(LOW_CYC));
        end
        hi_run = 1;
      end else if (sclk) begin
        hi_run++;
      end
      if (!sclk && prev_sclk) begin
        if (!pd_mode) chk("R3 high time", 32'(hi_run), 32'(HIGH_CYC));
        lo_run = 1;
      end else if (!sclk) begin
        lo_run++;
      end
      prev_sclk = sclk;
    end
  end

  task automatic do_read(input logic [23:0] w, input logic [1:0] c, input int exp_p,
                         input string req, input bit mid);
    bit got = 0;
    pulses = 0; dev_word = w; dev_cnt = 0; since_fall = 0;
    @(negedge clk); cfg = c; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; cfg = ~c;
    chk("R1 busy after request", 32'(busy), 32'd1);
    repeat (7) @(negedge clk);
    chk("R1 no pulse before ready", 32'(sclk), 32'd0);
    sdata = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (vld) got = 1;
      else if (mid && pulses == 3 && !pd_req) begin rd_req = 1'b1; pd_req = 1'b1; end
      else rd_req = 1'b0;
    end
    rd_req = 1'b0;
    chk("R6 valid strobe seen", 32'(got), 32'd1);
    chk({req, " result word"}, result, {{8{w[23]}}, w});
    chk("R5 pulse total", 32'(pulses), 32'(exp_p));
    if (mid) begin
      pd_mode = 1;
      chk("R9 power-down held off during read", 32'(pdn), 32'd0);
    end
    @(negedge clk);
    chk("R6 strobe lasts one cycle", 32'(vld), 32'd0);
    chk("R9 no second read accepted", 32'(busy), 32'd0);
    if (mid) begin
      @(negedge clk);
      chk("R9 deferred power-down drives clock", 32'(sclk), 32'd1);
      pd_req = 1'b0;
      @(negedge clk);
      chk("R8 release lowers clock", 32'(sclk), 32'd0);
      repeat (20) @(negedge clk);
      chk("R9 still idle", 32'(busy), 32'd0);
      pd_mode = 0;
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int k;
    bit seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clock low", 32'(sclk), 32'd0);
    chk("R1 reset not busy", 32'(busy), 32'd0);
    chk("R6 reset no strobe", 32'(vld), 32'd0);
    chk("R8 reset not powered down", 32'(pdn), 32'd0);
    chk("R10 reset no timeout", 32'(tout), 32'd0);

    do_read(24'h000001, 2'b00, 25, "R4", 0);
    do_read(24'h800000, 2'b01, 26, "R7", 0);
    do_read(24'h7FFFFF, 2'b10, 27, "R7", 0);
    do_read(24'hA5A5A5, 2'b11, 25, "R5", 0);
    do_read(24'h123456, 2'b00, 25, "R4", 1);

    // R10: ready never arrives
    pulses = 0; dev_cnt = 99;
    @(negedge clk); rd_req = 1'b1;
    k = 0; seen = 0;
    @(negedge clk); rd_req = 1'b0; k = 1;
    if (tout) seen = 1;
    while (!seen && k < 5000) begin
      @(negedge clk); k++;
      if (tout) seen = 1;
    end
    chk("R10 timeout cycle", 32'(k), 32'(TIMEOUT_CYC + 1));
    chk("R10 no pulses", 32'(pulses), 32'd0);
    @(negedge clk);
    chk("R10 strobe one cycle", 32'(tout), 32'd0);
    chk("R10 back to idle", 32'(busy), 32'd0);

    // R8: power-down wins over a simultaneous read request
    pd_mode = 1; dev_cnt = 99;
    @(negedge clk); pd_req = 1'b1; rd_req = 1'b1;
    k = 0; seen = 0;
    @(negedge clk); rd_req = 1'b0;
    chk("R8 power-down has priority", 32'(busy), 32'd0);
    if (pdn) seen = 1; else if (sclk) k++;
    while (!seen && k < 5000) begin
      @(negedge clk);
      if (pdn) seen = 1; else if (sclk) k++;
    end
    chk("R8 hold length", 32'(k), 32'(PD_HOLD_CYC));
    chk("R8 clock high when down", 32'(sclk), 32'd1);
    repeat (10) @(negedge clk);
    chk("R8 flag stays", 32'(pdn), 32'd1);
    pd_req = 1'b0;
    @(negedge clk);
    chk("R8 wake lowers clock", 32'(sclk), 32'd0);
    chk("R8 wake clears flag", 32'(pdn), 32'd0);
    repeat (5) @(negedge clk);
    pd_mode = 0;

    do_read(24'hF00001, 2'b01, 26, "R6", 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule